// File: doc/BRIEF.md
# Next Fetch Address Unit

This combinational unit picks the address from which the next instruction word is fetched. By default it steps the current program counter forward by one 4-byte instruction word. A conditional branch that is taken redirects to a target relative to the already-stepped address. A direct jump replaces the low address bits with a 26-bit word index taken from the instruction. A register-indirect jump loads an address held in a register. The unit also drives a link value: the address of the instruction that follows. A call-and-link instruction writes this value to the return-address register.

The control inputs come from the instruction decoder. The equality flag comes from the register comparator. The unit has no state, so both outputs follow the inputs within the same cycle. Hazards, delay slots and the instruction memory belong to other blocks.

Top module: `npc_unit`

## Requirements
- R1: With every control input low, `pc_next` equals `pc_cur + 4`.
- R2: With `is_beq` high and `ops_equal` high, `pc_next` equals `(pc_cur + 4) + (sign-extended br_ofs << 2)`. With `is_beq` high and `ops_equal` low, `pc_next` equals `pc_cur + 4`.
- R3: With `is_bne` high and `ops_equal` low, `pc_next` equals the same relative target as in R2. With `is_bne` high and `ops_equal` high, `pc_next` equals `pc_cur + 4`.
- R4: `br_ofs` is a signed count of words, with bit 15 as its sign. An offset of 0xFFFF moves the target back by 4 bytes, and 0x8000 moves it back by 0x20000 bytes.
- R5: With `is_jmp` high, `pc_next` equals `{(pc_cur+4)[31:28], jmp_field, 2'b00}`.
- R6: The four region bits of a direct jump come from `pc_cur + 4`, not from `pc_cur`. At `pc_cur` = 0x0FFFFFFC the region is 0x1.
- R7: With `is_jal` high, `pc_next` is the same target as in R5.
- R8: `link_addr` always equals `pc_cur + 4`, whatever the control inputs are.
- R9: With `is_jreg` high, `pc_next` equals `reg_tgt`. This holds even when other control inputs are high.
- R10: A direct jump (`is_jmp` or `is_jal`) wins over a taken branch when both are asserted.
- R11: Address arithmetic wraps modulo 2^32. At `pc_cur` = 0xFFFFFFFC, the sequential address is 0.
- R12: At `pc_cur` = 80012, a taken not-equal branch with offset 2 gives 80024. A direct jump with field 20000 from `pc_cur` = 80020 gives 80000.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| pc_cur | input | 32 | Address of the current instruction |
| br_ofs | input | 16 | Signed branch offset in words |
| jmp_field | input | 26 | Word index of a direct jump |
| reg_tgt | input | 32 | Register operand for the register-indirect jump |
| ops_equal | input | 1 | High when the two compared registers are equal |
| is_beq | input | 1 | Branch if the registers are equal |
| is_bne | input | 1 | Branch if the registers differ |
| is_jmp | input | 1 | Direct jump |
| is_jal | input | 1 | Direct jump that also links |
| is_jreg | input | 1 | Register-indirect jump |
| pc_next | output | 32 | Next fetch address |
| link_addr | output | 32 | Return address, equal to pc_cur + 4 |

## Verification
The bench targets carries that cross the split point of the adder (0x0FFFFFFC, and the full wrap at 0xFFFFFFFC). An adder that loses the carry between its halves would produce an address in the wrong 64 KiB block or the wrong region. It uses negative offsets, including the most negative one. A unit that zero-extended the offset would jump forward by almost 256 KiB instead of back. It takes the jump region from an address just below a region boundary. A unit that used the unstepped counter would stay in region 0. It also asserts several redirects at once. A wrong priority order would follow the branch or the direct jump instead of the register.

// File: rtl/npc_pkg.sv
package npc_pkg;

  // Source of the next fetch address, listed from lowest to highest priority.
  typedef enum logic [1:0] {
    SRC_SEQ    = 2'd0,
    SRC_BRANCH = 2'd1,
    SRC_DIRECT = 2'd2,
    SRC_REG    = 2'd3
  } npc_src_e;

  // Adder implementation choices.
  localparam int ADD_RIPPLE = 0;
  localparam int ADD_CSEL   = 1;

endpackage

// File: rtl/npc_adder.sv
module npc_adder #(
  parameter int W    = 32,
  parameter int IMPL = npc_pkg::ADD_CSEL
) (
  input  logic [W-1:0] op_a,
  input  logic [W-1:0] op_b,
  output logic [W-1:0] sum
);

  localparam int LO_W = W / 2;
  localparam int HI_W = W - LO_W;

  generate
    if (IMPL == npc_pkg::ADD_CSEL) begin : g_csel
      logic [LO_W:0]   lo_sum;
      logic [HI_W-1:0] hi_c0;
      logic [HI_W-1:0] hi_c1;

      // The low half runs alone; the high half is computed for both carry-in
      // values, and the carry out of the low half selects one of them.
      always_comb begin
        lo_sum = {1'b0, op_a[LO_W-1:0]} + {1'b0, op_b[LO_W-1:0]};
        hi_c0  = op_a[W-1:LO_W] + op_b[W-1:LO_W];
        hi_c1  = op_a[W-1:LO_W] + op_b[W-1:LO_W] + HI_W'(1);
        sum    = {(lo_sum[LO_W] ? hi_c1 : hi_c0), lo_sum[LO_W-1:0]};
      end
    end else begin : g_ripple
      always_comb sum = op_a + op_b;
    end
  endgenerate

endmodule

// File: rtl/npc_target_form.sv
module npc_target_form #(
  parameter int ADDR_W   = 32,
  parameter int OFF_W    = 16,
  parameter int JFIELD_W = 26,
  parameter int SHIFT    = 2,
  localparam int REGION_W = ADDR_W - JFIELD_W - SHIFT,
  localparam int EXT_W    = ADDR_W - OFF_W - SHIFT
) (
  input  logic [OFF_W-1:0]    br_ofs,
  input  logic [JFIELD_W-1:0] jmp_field,
  input  logic [REGION_W-1:0] region,
  output logic [ADDR_W-1:0]   ofs_bytes,
  output logic [ADDR_W-1:0]   direct_tgt
);

  always_comb begin
    // Sign-extend the word offset and scale it to bytes.
    ofs_bytes  = {{EXT_W{br_ofs[OFF_W-1]}}, br_ofs, {SHIFT{1'b0}}};
    // Keep the region bits and replace the rest with the word index.
    direct_tgt = {region, jmp_field, {SHIFT{1'b0}}};
  end

endmodule

// File: rtl/npc_select.sv
module npc_select #(
  parameter int ADDR_W = 32
) (
  input  logic              ops_equal,
  input  logic              is_beq,
  input  logic              is_bne,
  input  logic              is_jmp,
  input  logic              is_jal,
  input  logic              is_jreg,
  input  logic [ADDR_W-1:0] seq_addr,
  input  logic [ADDR_W-1:0] branch_tgt,
  input  logic [ADDR_W-1:0] direct_tgt,
  input  logic [ADDR_W-1:0] reg_tgt,
  output logic [ADDR_W-1:0] pc_next
);

  import npc_pkg::*;

  logic     br_taken;
  npc_src_e src;

  always_comb begin
    br_taken = (is_beq & ops_equal) | (is_bne & ~ops_equal);
    if (is_jreg)               src = SRC_REG;
    else if (is_jmp | is_jal)  src = SRC_DIRECT;
    else if (br_taken)         src = SRC_BRANCH;
    else                       src = SRC_SEQ;
  end

  always_comb begin
    unique case (src)
      SRC_REG:    pc_next = reg_tgt;
      SRC_DIRECT: pc_next = direct_tgt;
      SRC_BRANCH: pc_next = branch_tgt;
      default:    pc_next = seq_addr;
    endcase
  end

endmodule

// File: rtl/npc_unit.sv
module npc_unit #(
  parameter int ADDR_W     = 32,
  parameter int OFF_W      = 16,
  parameter int JFIELD_W   = 26,
  parameter int INSN_BYTES = 4,
  parameter int ADD_IMPL   = npc_pkg::ADD_CSEL
) (
  input  logic [ADDR_W-1:0]   pc_cur,
  input  logic [OFF_W-1:0]    br_ofs,
  input  logic [JFIELD_W-1:0] jmp_field,
  input  logic [ADDR_W-1:0]   reg_tgt,
  input  logic                ops_equal,
  input  logic                is_beq,
  input  logic                is_bne,
  input  logic                is_jmp,
  input  logic                is_jal,
  input  logic                is_jreg,
  output logic [ADDR_W-1:0]   pc_next,
  output logic [ADDR_W-1:0]   link_addr
);

  localparam int SHIFT    = $clog2(INSN_BYTES);
  localparam int REGION_W = ADDR_W - JFIELD_W - SHIFT;

  logic [ADDR_W-1:0] seq_addr;
  logic [ADDR_W-1:0] ofs_bytes;
  logic [ADDR_W-1:0] branch_tgt;
  logic [ADDR_W-1:0] direct_tgt;

  npc_adder #(.W(ADDR_W), .IMPL(ADD_IMPL)) u_step (
    .op_a (pc_cur),
    .op_b (ADDR_W'(INSN_BYTES)),
    .sum  (seq_addr)
  );

  npc_target_form #(
    .ADDR_W(ADDR_W), .OFF_W(OFF_W), .JFIELD_W(JFIELD_W), .SHIFT(SHIFT)
  ) u_form (
    .br_ofs     (br_ofs),
    .jmp_field  (jmp_field),
    .region     (seq_addr[ADDR_W-1 -: REGION_W]),
    .ofs_bytes  (ofs_bytes),
    .direct_tgt (direct_tgt)
  );

  npc_adder #(.W(ADDR_W), .IMPL(ADD_IMPL)) u_rel (
    .op_a (seq_addr),
    .op_b (ofs_bytes),
    .sum  (branch_tgt)
  );

  npc_select #(.ADDR_W(ADDR_W)) u_sel (
    .ops_equal  (ops_equal),
    .is_beq     (is_beq),
    .is_bne     (is_bne),
    .is_jmp     (is_jmp),
    .is_jal     (is_jal),
    .is_jreg    (is_jreg),
    .seq_addr   (seq_addr),
    .branch_tgt (branch_tgt),
    .direct_tgt (direct_tgt),
    .reg_tgt    (reg_tgt),
    .pc_next    (pc_next)
  );

  assign link_addr = seq_addr;

endmodule

// File: rtl/npc_unit_chk.sv
module npc_unit_chk #(
  parameter int ADDR_W   = 32,
  parameter int OFF_W    = 16,
  parameter int JFIELD_W = 26
) (
  input logic [ADDR_W-1:0]   pc_cur,
  input logic [OFF_W-1:0]    br_ofs,
  input logic [JFIELD_W-1:0] jmp_field,
  input logic [ADDR_W-1:0]   reg_tgt,
  input logic                ops_equal,
  input logic                is_beq,
  input logic                is_bne,
  input logic                is_jmp,
  input logic                is_jal,
  input logic                is_jreg,
  input logic [ADDR_W-1:0]   pc_next,
  input logic [ADDR_W-1:0]   link_addr
);

  localparam int LOW_W = JFIELD_W + 2;

  logic any_ctl;
  logic taken;
  logic jumping;

  always_comb begin
    any_ctl = is_beq | is_bne | is_jmp | is_jal | is_jreg;
    taken   = (is_beq & ops_equal) | (is_bne & ~ops_equal);
    jumping = is_jmp | is_jal;

    AST_LINK_STEP: assert (link_addr == pc_cur + ADDR_W'(4)) else $error("link");             // R8
    AST_IDLE_STEP: assert (any_ctl || pc_next == link_addr) else $error("idle");              // R1
    AST_REG_FIRST: assert (!is_jreg || pc_next == reg_tgt) else $error("jreg");               // R9
    AST_DIRECT_LOW: assert (is_jreg || !jumping ||
                            pc_next[LOW_W-1:0] == {jmp_field, 2'b00}) else $error("jlow");    // R5
    AST_DIRECT_REGION: assert (is_jreg || !jumping ||
                               pc_next[ADDR_W-1:LOW_W] == link_addr[ADDR_W-1:LOW_W])
                       else $error("region");                                                 // R6
    AST_BRANCH_REL: assert (is_jreg || jumping || !taken ||
                            pc_next == link_addr + ADDR_W'($signed(br_ofs)) * ADDR_W'(4))
                    else $error("branch");                                                    // R2
    AST_NOT_TAKEN: assert (is_jreg || jumping || taken || pc_next == link_addr)
                   else $error("nottaken");                                                   // R3
  end

endmodule

bind npc_unit npc_unit_chk #(
  .ADDR_W(ADDR_W), .OFF_W(OFF_W), .JFIELD_W(JFIELD_W)
) u_chk (.*);

// File: tb/sim_npc_unit.sv
module sim_npc_unit;

  localparam int CLK_PERIOD = 10;

  typedef struct {
    string       req;
    logic [31:0] nx;
    logic [31:0] lk;
  } exp_t;

  logic        clk;
  logic        rst_n;
  logic [31:0] pc_cur;
  logic [15:0] br_ofs;
  logic [25:0] jmp_field;
  logic [31:0] reg_tgt;
  logic        ops_equal, is_beq, is_bne, is_jmp, is_jal, is_jreg;
  logic [31:0] pc_next, link_addr;

  int   total = 0;
  int   bad   = 0;
  bit   done  = 0;
  exp_t sb_q[$];

  npc_unit u0 (
    .pc_cur(pc_cur), .br_ofs(br_ofs), .jmp_field(jmp_field), .reg_tgt(reg_tgt),
    .ops_equal(ops_equal), .is_beq(is_beq), .is_bne(is_bne), .is_jmp(is_jmp),
    .is_jal(is_jal), .is_jreg(is_jreg), .pc_next(pc_next), .link_addr(link_addr)
  );

  initial clk = 1'b0;
  always #(CLK_PERIOD/2) clk = ~clk;

  // Controls are given as {jreg, jal, jmp, bne, beq}.
  task automatic drive(input string req, input logic [31:0] pc, input logic [15:0] ofs,
                       input logic [25:0] fld, input logic [31:0] rv, input logic eq,
                       input logic [4:0] ctl, input logic [31:0] exp_nx);
    exp_t e;
    @(posedge clk);
    pc_cur = pc; br_ofs = ofs; jmp_field = fld; reg_tgt = rv; ops_equal = eq;
    {is_jreg, is_jal, is_jmp, is_bne, is_beq} = ctl;
    e.req = req; e.nx = exp_nx; e.lk = pc + 32'd4;
    sb_q.push_back(e);
  endtask

  always @(negedge clk) begin
    if (rst_n && sb_q.size() > 0) begin
      exp_t e;
      e = sb_q.pop_front();
      total += 2;
      if (pc_next !== e.nx) begin
        bad++;
        $display("FAIL %s pc_next actual=%h expected=%h", e.req, pc_next, e.nx);
      end
      if (link_addr !== e.lk) begin
        bad++;
        $display("FAIL %s link_addr actual=%h expected=%h", e.req, link_addr, e.lk);
      end
    end
  end

  initial begin
    rst_n = 1'b0;
    pc_cur = '0; br_ofs = '0; jmp_field = '0; reg_tgt = '0; ops_equal = 1'b0;
    {is_jreg, is_jal, is_jmp, is_bne, is_beq} = '0;
    repeat (3) @(posedge clk);
    rst_n = 1'b1;

    drive("R1", 32'h0, 16'h0, 26'h0, 32'h0, 1'b0, 5'b00000, 32'h4);                       // reset-like idle
    drive("R1", 32'h00400020, 16'h1234, 26'h15, 32'h99, 1'b1, 5'b00000, 32'h00400024);
    drive("R2", 32'h1000, 16'h0010, 26'h0, 32'h0, 1'b1, 5'b00001, 32'h1044);
    drive("R2", 32'h1000, 16'h0010, 26'h0, 32'h0, 1'b0, 5'b00001, 32'h1004);
    drive("R3", 32'h2000, 16'h0003, 26'h0, 32'h0, 1'b0, 5'b00010, 32'h2010);
    drive("R3", 32'h2000, 16'h0003, 26'h0, 32'h0, 1'b1, 5'b00010, 32'h2004);
    drive("R4", 32'h3000, 16'hFFFF, 26'h0, 32'h0, 1'b1, 5'b00001, 32'h3000);
    drive("R4", 32'h00100000, 16'h8000, 26'h0, 32'h0, 1'b0, 5'b00010, 32'h000E0004);
    drive("R5", 32'h00400000, 16'h0, 26'h0100000, 32'h0, 1'b0, 5'b00100, 32'h00400000);
    drive("R5", 32'hA0000000, 16'h0, 26'h3FFFFFF, 32'h0, 1'b0, 5'b00100, 32'hAFFFFFFC);
    drive("R6", 32'h0FFFFFFC, 16'h0, 26'h0000010, 32'h0, 1'b0, 5'b00100, 32'h10000040);
    drive("R7", 32'h00400100, 16'h0, 26'h0000040, 32'h0, 1'b0, 5'b01000, 32'h00000100);
    drive("R8", 32'h00000500, 16'h7FFF, 26'h0, 32'h00001234, 1'b1, 5'b10000, 32'h00001234);
    drive("R9", 32'h00000100, 16'h0004, 26'h20, 32'hDEAD0000, 1'b1, 5'b11111, 32'hDEAD0000);
    drive("R10", 32'h00000100, 16'h0005, 26'h20, 32'h0, 1'b0, 5'b00110, 32'h00000080);
    drive("R10", 32'h00000100, 16'h0005, 26'h20, 32'h0, 1'b1, 5'b01001, 32'h00000080);
    drive("R11", 32'hFFFFFFFC, 16'h0, 26'h0, 32'h0, 1'b0, 5'b00000, 32'h00000000);
    drive("R11", 32'hFFFFFFFC, 16'h0001, 26'h0, 32'h0, 1'b1, 5'b00001, 32'h00000004);
    drive("R12", 32'd80012, 16'd2, 26'h0, 32'h0, 1'b0, 5'b00010, 32'd80024);
    drive("R12", 32'd80020, 16'h0, 26'd20000, 32'h0, 1'b0, 5'b00100, 32'd80000);

    @(posedge clk);
    @(negedge clk);
    #1;
    if (sb_q.size() != 0) begin
      bad++; total++;
      $display("FAIL scoreboard left=%0d expected=0", sb_q.size());
    end
    if (!done) begin
      done = 1;
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    repeat (5000) @(posedge clk);
    if (!done) begin
      done = 1;
      bad++; total++;
      $display("FAIL watchdog actual=expired expected=finished");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

endmodule